// File: doc/BRIEF.md
# Timer-Paced Sample FIFO Channel

This block is a single streaming audio channel. A bus master, normally a DMA engine in a FIFO-fill mode, sometimes the CPU for the first word, writes packed signed 8-bit samples into a small word-wide FIFO. Each word holds four samples. A word can arrive either as one full-width write or as a low halfword followed by a high halfword. The high half commits the word.

Playback is paced by timer overflow pulses. A select input picks which of the timer pulses counts. On each selected pulse the block takes the next byte of the head word and holds it on `sample_o` until the next pulse. That output feeds a PWM or mixing stage that may sample it at any time. When a pop leaves the FIFO at or below a refill level, the block pulses a refill request to the DMA engine. A synchronous clear empties the FIFO, rewinds the byte sequencer and returns the output to the zero level 00h.

Top module: `paced_sample_fifo`

## Requirements
- R1: Within a committed 32-bit word the samples play out in this order: bits 7:0, then 15:8, then 23:16, then 31:24. After the last of them, the next word starts.
- R2: A write with only `wr_lo_i` high stores bits 15:0 and commits nothing. A later write with only `wr_hi_i` high commits {bits 31:16 of that write, stored low half}. A write with both strobes high commits all 32 bits at once.
- R3: With `tmr_sel_i` = k, only `tmr_ovf_i[k]` advances playback. Pulses on the other timer input have no effect on `sample_o`.
- R4: `sample_o` takes its new value in the cycle after the selected pulse. It does not change in any cycle without a selected pulse or a clear.
- R5: `clr_i` empties the FIFO, resets the byte position to sample 0, and drives `sample_o` to 00h. It also drops `underflow_o`, `overflow_o` and `dma_req_o`, and discards a staged low half. After reset the same state holds.
- R6: `dma_req_o` is high for exactly one cycle after each pop that leaves 4 or fewer words in the FIFO. It stays low after pops that leave more than 4 words.
- R7: A selected pulse while the FIFO is empty leaves `sample_o` unchanged and sets the sticky `underflow_o`.
- R8: A commit while the FIFO holds 8 words is dropped and sets the sticky `overflow_o`. The stored words are not disturbed.
- R9: The FIFO holds 8 words (32 samples) and returns them in write order.
- R10: Sample bytes pass through unaltered as two's complement values, including 80h (-128) and 7Fh (+127).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Software clear of FIFO, sequencer, output and status |
| tmr_sel_i | input | 1 | Index of the timer pulse that paces playback |
| tmr_ovf_i | input | 2 | Timer overflow pulses, one per timer |
| wr_lo_i | input | 1 | Low-halfword write strobe |
| wr_hi_i | input | 1 | High-halfword write strobe (both strobes high means a full word) |
| wr_data_i | input | 32 | Write data, halfwords on their natural lanes |
| sample_o | output | 8 | Current signed sample |
| dma_req_o | output | 1 | One-cycle refill request |
| underflow_o | output | 1 | Sticky: a pulse found the FIFO empty |
| overflow_o | output | 1 | Sticky: a commit found the FIFO full |

## Verification
The hardest states to reach from the ports are the full-FIFO drop and the exact boundary of the refill threshold. Both require eight committed words with no playback in between, followed by a drain of all 32 samples, one pulse at a time. The bench writes a ninth word into a full FIFO, then checks the refill request on every pop across the 5-to-4 word boundary. A lone low-halfword write is followed by a pulse. That pulse must underflow rather than play, which shows that staging alone commits nothing.

// File: rtl/afc_pkg.sv
package afc_pkg;
   typedef enum logic [0:0] {
      TICK_COMB = 1'b0,
      TICK_REG  = 1'b1
   } tick_mode_e;

   function automatic int min1_clog2(input int v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/afc_tick_sel.sv
module afc_tick_sel
   import afc_pkg::*;
#(
   parameter int         N_TMR = 2,
   parameter tick_mode_e MODE  = TICK_COMB,
   localparam int        SEL_W = min1_clog2(N_TMR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_TMR-1:0] ovf,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic raw;

   always_comb begin
      raw = 1'b0;
      for (int i = 0; i < N_TMR; i++) begin
         if (sel == SEL_W'(i)) raw = ovf[i];
      end
   end

   generate
      if (MODE == TICK_REG) begin : g_reg
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) tick_q <= 1'b0;
            else               tick_q <= raw;
         end
         assign tick = tick_q;
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, clr};
         assign tick = raw;
      end
   endgenerate
endmodule

// File: rtl/afc_wr_stage.sv
module afc_wr_stage #(
   parameter int  WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wr_data,
   output logic              push,
   output logic [WORD_W-1:0] push_word
);
   logic [HALF_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)        stage_q <= '0;
      else if (wr_lo && !wr_hi) stage_q <= wr_data[HALF_W-1:0];
   end

   assign push      = wr_hi && !clr;
   assign push_word = wr_lo ? wr_data : {wr_data[WORD_W-1:HALF_W], stage_q};
endmodule

// File: rtl/afc_word_fifo.sv
module afc_word_fifo #(
   parameter int  WORD_W = 32,
   parameter int  DEPTH  = 8,
   localparam int AW     = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic              empty,
   output logic              drop,
   output logic [CNT_W-1:0]  lvl_nxt
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr_q, rptr_q;
   logic [CNT_W-1:0]  count_q;
   logic              full, push_ok, pop_ok;

   assign full    = (count_q == CNT_W'(DEPTH));
   assign empty   = (count_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign drop    = push && full;
   assign lvl_nxt = clr ? '0 : count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
   assign head    = mem[rptr_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr_q] <= push_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + AW'(1);
         if (pop_ok)  rptr_q <= rptr_q + AW'(1);
         count_q <= lvl_nxt;
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH)); // R9
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count_q == CNT_W'(DEPTH))); // R8
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R5
endmodule

// File: rtl/afc_byte_seq.sv
module afc_byte_seq
   import afc_pkg::*;
#(
   parameter int  SAMPLE_W = 8,
   parameter int  LANES    = 4,
   localparam int WORD_W   = SAMPLE_W * LANES,
   localparam int IW       = min1_clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                tick,
   input  logic [WORD_W-1:0]   head,
   input  logic                empty,
   output logic [SAMPLE_W-1:0] sample,
   output logic                pop,
   output logic                underrun
);
   logic [SAMPLE_W-1:0] lane [LANES];
   logic [IW-1:0]       idx_q;
   logic [SAMPLE_W-1:0] sample_q;
   logic                take, at_last;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane[g] = head[g*SAMPLE_W +: SAMPLE_W];
      end
   endgenerate

   assign take     = tick && !empty && !clr;
   assign at_last  = (idx_q == IW'(LANES - 1));
   assign pop      = take && at_last;
   assign underrun = tick && empty && !clr;
   assign sample   = sample_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         idx_q    <= '0;
         sample_q <= '0;
      end else if (take) begin
         sample_q <= lane[idx_q];
         idx_q    <= at_last ? '0 : idx_q + IW'(1);
      end
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(sample_q)); // R4
   AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && empty && !clr) |=> $stable(sample_q)); // R7
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sample_q == '0 && idx_q == '0)); // R5
endmodule

// File: rtl/paced_sample_fifo.sv
module paced_sample_fifo
   import afc_pkg::*;
#(
   parameter int         SAMPLE_W   = 8,
   parameter int         LANES      = 4,
   parameter int         DEPTH      = 8,
   parameter int         REFILL_LVL = 4,
   parameter int         N_TMR      = 2,
   parameter tick_mode_e TICK_MODE  = TICK_COMB,
   localparam int        WORD_W     = SAMPLE_W * LANES,
   localparam int        SEL_W      = min1_clog2(N_TMR),
   localparam int        CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic [SEL_W-1:0]    tmr_sel_i,
   input  logic [N_TMR-1:0]    tmr_ovf_i,
   input  logic                wr_lo_i,
   input  logic                wr_hi_i,
   input  logic [WORD_W-1:0]   wr_data_i,
   output logic [SAMPLE_W-1:0] sample_o,
   output logic                dma_req_o,
   output logic                underflow_o,
   output logic                overflow_o
);
   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("LANES must be even and at least 2");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (REFILL_LVL < 0 || REFILL_LVL >= DEPTH) begin : g_bad_lvl
         $error("REFILL_LVL must lie below DEPTH");
      end
   endgenerate

   logic              tick, push, pop, empty, drop, underrun;
   logic [WORD_W-1:0] push_word, head;
   logic [CNT_W-1:0]  lvl_nxt;
   logic              req_q, uf_q, of_q;

   afc_tick_sel #(.N_TMR(N_TMR), .MODE(TICK_MODE)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(clr_i),
      .ovf(tmr_ovf_i), .sel(tmr_sel_i), .tick(tick));

   afc_wr_stage #(.WORD_W(WORD_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .clr(clr_i),
      .wr_lo(wr_lo_i), .wr_hi(wr_hi_i), .wr_data(wr_data_i),
      .push(push), .push_word(push_word));

   afc_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr_i),
      .push(push), .push_word(push_word), .pop(pop),
      .head(head), .empty(empty), .drop(drop), .lvl_nxt(lvl_nxt));

   afc_byte_seq #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr(clr_i), .tick(tick),
      .head(head), .empty(empty),
      .sample(sample_o), .pop(pop), .underrun(underrun));

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         req_q <= 1'b0;
         uf_q  <= 1'b0;
         of_q  <= 1'b0;
      end else begin
         req_q <= pop && (lvl_nxt <= CNT_W'(REFILL_LVL));
         if (underrun) uf_q <= 1'b1;
         if (drop)     of_q <= 1'b1;
      end
   end

   assign dma_req_o   = req_q;
   assign underflow_o = uf_q;
   assign overflow_o  = of_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |=> !dma_req_o); // R6
   AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!dma_req_o && !underflow_o && !overflow_o)); // R5
   AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && !clr_i) |=> underflow_o); // R7
   AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !clr_i) |=> overflow_o); // R8
endmodule

// File: tb/paced_sample_fifo_bench.sv
`timescale 1ns/1ps
module paced_sample_fifo_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic [0:0]  tmr_sel = 1'b0;
   logic [1:0]  tmr_ovf = 2'b00;
   logic        wr_lo = 1'b0, wr_hi = 1'b0;
   logic [31:0] wr_data = '0;
   logic [7:0]  sample;
   logic        dma_req, uf, of;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [7:0] exp_q [$];
   logic [7:0] last_exp = 8'h00;
   bit         pend = 0, exp_req = 0;

   always #5 clk = ~clk;

   paced_sample_fifo u_paced_sample_fifo (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .tmr_sel_i(tmr_sel),
      .tmr_ovf_i(tmr_ovf), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
      .wr_data_i(wr_data), .sample_o(sample), .dma_req_o(dma_req),
      .underflow_o(uf), .overflow_o(of));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: pop expected byte at the edge that sees a selected pulse
   always @(posedge clk) begin
      pend = 0;
      exp_req = 0;
      if (rst_n && !clr && tmr_ovf[tmr_sel] && exp_q.size() > 0) begin
         last_exp = exp_q.pop_front();
         pend = 1;
         if (exp_q.size() % 4 == 0 && exp_q.size() / 4 <= 4) exp_req = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (pend) chk(sample == last_exp, "R1/R9/R10 sample order", {24'h0, sample}, {24'h0, last_exp});
         if (exp_req || dma_req) chk(dma_req == exp_req, "R6 refill request", {31'h0, dma_req}, {31'h0, exp_req});
      end
   end

   // Driver: commits a word and records its bytes as expected items
   task automatic write_word(input logic [31:0] w, input bit split);
      bit room;
      if (split) begin
         @(negedge clk); wr_lo = 1; wr_hi = 0; wr_data = {16'h0, w[15:0]};
         @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = {w[31:16], 16'h0};
      end else begin
         @(negedge clk); wr_lo = 1; wr_hi = 1; wr_data = w;
      end
      room = ((exp_q.size() + 3) / 4) < 8;
      if (room) for (int i = 0; i < 4; i++) exp_q.push_back(w[i*8 +: 8]);
      @(negedge clk); wr_lo = 0; wr_hi = 0; wr_data = '0;
   endtask

   task automatic pulse(input int k);
      @(negedge clk); tmr_ovf[k] = 1'b1;
      @(negedge clk); tmr_ovf = 2'b00;
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      exp_q.delete();
      @(negedge clk); clr = 1'b0;
      last_exp = 8'h00;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sample == 8'h00, "R5 reset sample", {24'h0, sample}, 32'h0);
      chk({dma_req, uf, of} == 3'b000, "R5 reset status", {29'h0, dma_req, uf, of}, 32'h0);

      // R1 R10 R6: full-word write, four samples, request after last pop
      write_word(32'h7F80_01FF, 0);
      for (int i = 0; i < 4; i++) pulse(0);
      chk(sample == 8'h7F, "R10 max positive", {24'h0, sample}, 32'h7F);

      // R2 R7: low half alone must not commit; pulse underflows and holds
      @(negedge clk); wr_lo = 1; wr_data = 32'h0000_2211;
      @(negedge clk); wr_lo = 0; wr_data = '0;
      pulse(0);
      chk(sample == 8'h7F, "R7 hold on empty", {24'h0, sample}, 32'h7F);
      chk(uf == 1'b1, "R2/R7 staged half did not commit", {31'h0, uf}, 32'h1);
      @(negedge clk); wr_hi = 1; wr_data = 32'h4433_0000;
      for (int i = 0; i < 4; i++) exp_q.push_back(8'h11 + 8'(i * 8'h11));
      @(negedge clk); wr_hi = 0; wr_data = '0;
      pulse(0); pulse(0);

      // R3: timer 0 ignored once timer 1 is selected
      @(negedge clk); tmr_sel = 1'b1;
      held = sample;
      pulse(0);
      repeat (2) @(negedge clk);
      chk(sample == held, "R3 unselected timer ignored", {24'h0, sample}, {24'h0, held});
      pulse(1);
      chk(sample == 8'h33, "R3 selected timer advances", {24'h0, sample}, 32'h33);

      // R4: stable with no pulse
      held = sample;
      repeat (5) @(negedge clk);
      chk(sample == held, "R4 stable between pulses", {24'h0, sample}, {24'h0, held});

      // R5: clear mid-word
      do_clear();
      chk(sample == 8'h00, "R5 clear zeroes sample", {24'h0, sample}, 32'h0);
      chk({dma_req, uf, of} == 3'b000, "R5 clear status", {29'h0, dma_req, uf, of}, 32'h0);

      // R8 R9 R6: fill to 8, ninth dropped, drain all 32
      for (int w = 0; w < 9; w++) write_word({8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)} + 32'hA0A0_A0A0, w[0]);
      chk(of == 1'b1, "R8 overflow flag", {31'h0, of}, 32'h1);
      chk(exp_q.size() == 32, "R9 capacity", exp_q.size(), 32);
      for (int i = 0; i < 32; i++) pulse(1);
      chk(sample == 8'hBF, "R8/R9 last stored sample, ninth dropped", {24'h0, sample}, 32'hBF);
      chk(uf == 1'b0, "R7 no underflow while draining", {31'h0, uf}, 32'h0);
      pulse(1);
      chk(sample == 8'hBF, "R7 hold after drain", {24'h0, sample}, 32'hBF);
      chk(uf == 1'b1, "R7 underflow flag", {31'h0, uf}, 32'h1);

      // R5: sequencer restarts at byte 0 after clear
      write_word(32'h0403_0201, 0);
      pulse(1);
      do_clear();
      write_word(32'hD4C3_B2A1, 1);
      pulse(1);
      chk(sample == 8'hA1, "R5 sequencer reset", {24'h0, sample}, 32'hA1);

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule